// File: doc/BRIEF.md
# SPI Target Response Transmitter

This block drives the MISO line of an SPI target. Until a response is armed it answers every byte the host clocks with a single status byte that the CPU can rewrite at any time, so the host can poll it for progress. The CPU then fills a 256-byte transmit store with 32-bit word writes, marks the fill as done, and issues a start command. From the next byte boundary on, the block streams the stored bytes in order. When the store runs dry it falls back to the status byte. When chip select returns high, the block records an end-of-transaction flag, which can raise an interrupt. It also disarms the response and rewinds its read position.

The SPI pins are sampled in the system clock domain through two-stage synchronisers. SCLK must therefore stay at least four system clocks in each phase. The CPU side is a register port. Writes use a valid/ready handshake, and `reg_wr_ready_o` is held high, so a write is taken in the cycle where `reg_wr_valid_i` is high. A data word offered while the store is full is accepted and discarded rather than stalled. Reads are combinational from `reg_rd_addr_i`. Register word addresses: 0x0 control (bit0 enable, bit1 CPU fill access), 0x1 status byte, 0x2 command (bit0 store reset, bit1 count reset, bit2 fill done, bit3 start), 0x3 data word, 0x4 event flags (bit0 end detected, write one to clear), 0x5 event mask (bit0, 1 = masked), 0x6 store level in bytes. Unused and write-only addresses read as zero.

Top module: `spi_tx_target`

## Requirements
- R1: After reset, MISO and the interrupt are low, the enable, status byte, event flags and store level read 0, and the event mask bit reads 1.
- R2: With the enable bit (0x0 bit0) clear, MISO stays low and a chip-select release sets no event flag; MISO is also low whenever chip select is high.
- R3: While no response is armed, every byte the host clocks carries the status byte register (0x1), in SPI mode 0, most significant bit first. The byte is taken at the chip-select falling edge and again after each eighth falling SCLK edge, so a new status value shows in the next byte.
- R4: A word written to 0x3 enters the store only while control bit1 is set and fewer than 256 bytes are held; the level register (0x6) counts bytes in steps of four, up to 256.
- R5: Writing command bit0 or bit1 empties the store, sets the level to 0 and disarms any response.
- R6: A start command (bit3) arms the response only if fill-done (bit2) was set by an earlier write. Once armed, the stored bytes are sent in order, each word least significant byte first.
- R7: After the last stored byte has been sent, further clocked bytes carry the status byte.
- R8: A rising chip select while enabled sets event flag bit0, clears the armed and fill-done states and rewinds the read position; the stored data is kept.
- R9: The interrupt output is high exactly when event flag bit0 is set and mask bit0 is clear.
- R10: Writing a one to event flag bit0 clears it; if a chip-select release sets it in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | SPI serial clock from the host |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_miso_o | output | 1 | Serial data to the host |
| reg_wr_valid_i | input | 1 | Register write request |
| reg_wr_ready_o | output | 1 | Register write accepted (held high) |
| reg_wr_addr_i | input | 4 | Register write word address |
| reg_wr_data_i | input | 32 | Register write data |
| reg_rd_addr_i | input | 4 | Register read word address |
| reg_rd_data_o | output | 32 | Register read data |
| irq_o | output | 1 | End-of-transaction interrupt |

## Verification
Two events can land in the same cycle: a chip-select release that sets the end flag, and a CPU write-one-to-clear of that flag. The bench raises chip select just after a falling clock edge. It places the clearing write at the third rising edge after that, which is the edge where the synchronised release reaches the flag. The flag must read back as set, and a later clearing write on its own must then clear it. The rest of the bench runs a behavioural model of status, store, armed state and flags, and compares MISO with it on every sampled SCLK bit and on every idle clock.

// File: rtl/spi_tx_pkg.sv
`timescale 1ns/1ps
package spi_tx_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] ADDR_CTRL  = 4'h0;
  localparam logic [REG_AW-1:0] ADDR_STAT  = 4'h1;
  localparam logic [REG_AW-1:0] ADDR_CMD   = 4'h2;
  localparam logic [REG_AW-1:0] ADDR_DATA  = 4'h3;
  localparam logic [REG_AW-1:0] ADDR_EVT   = 4'h4;
  localparam logic [REG_AW-1:0] ADDR_MASK  = 4'h5;
  localparam logic [REG_AW-1:0] ADDR_LEVEL = 4'h6;

  localparam int CTRL_EN     = 0;
  localparam int CTRL_ACCESS = 1;
  localparam int CMD_RST     = 0;
  localparam int CMD_CNTRST  = 1;
  localparam int CMD_FILLED  = 2;
  localparam int CMD_START   = 3;
  localparam int EVT_END     = 0;
endpackage

// File: rtl/spi_tx_sync.sv
`timescale 1ns/1ps
module spi_tx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], pin_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = level_o & ~prev;
  assign fall_o  = ~level_o & prev;
endmodule

// File: rtl/spi_tx_fifo.sv
`timescale 1ns/1ps
module spi_tx_fifo #(
  parameter int WORD_W     = 32,
  parameter int FIFO_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          push_i,
  input  logic [WORD_W-1:0]             push_data_i,
  input  logic [$clog2(FIFO_BYTES)-1:0] rd_idx_i,
  output logic [$clog2(FIFO_BYTES):0]   level_o,
  output logic                          full_o,
  output logic [7:0]                    rd_byte_o
);
  localparam int BPW    = WORD_W / 8;
  localparam int BSEL_W = $clog2(BPW);
  localparam int DEPTH  = FIFO_BYTES / BPW;
  localparam int WA     = $clog2(DEPTH);
  localparam int PTR_W  = $clog2(FIFO_BYTES);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WA:0]       words;
  logic [WORD_W-1:0] rd_word;

  assign full_o  = (words == (WA+1)'(DEPTH));
  assign level_o = {words, {BSEL_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 words <= '0;
    else if (clr_i)             words <= '0;
    else if (push_i && !full_o) words <= words + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_i && !full_o && !clr_i) mem[words[WA-1:0]] <= push_data_i;
  end

  assign rd_word   = mem[rd_idx_i[PTR_W-1:BSEL_W]];
  assign rd_byte_o = rd_word[{rd_idx_i[BSEL_W-1:0], 3'b000} +: 8];
endmodule

// File: rtl/spi_tx_regs.sv
`timescale 1ns/1ps
module spi_tx_regs
  import spi_tx_pkg::*;
#(
  parameter int LVL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [REG_DW-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [REG_DW-1:0] rd_data_o,
  input  logic              end_evt_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic              enable_o,
  output logic              access_o,
  output logic [7:0]        status_o,
  output logic              fifo_clr_o,
  output logic              push_o,
  output logic              armed_o,
  output logic              evt_end_o,
  output logic              irq_o
);
  logic fill_done, mask_end;
  logic cmd_wr, evt_wr;

  assign cmd_wr     = wr_valid_i && (wr_addr_i == ADDR_CMD);
  assign evt_wr     = wr_valid_i && (wr_addr_i == ADDR_EVT);
  assign fifo_clr_o = cmd_wr && (wr_data_i[CMD_RST] || wr_data_i[CMD_CNTRST]);
  assign push_o     = wr_valid_i && (wr_addr_i == ADDR_DATA) && access_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o  <= 1'b0;
      access_o  <= 1'b0;
      status_o  <= 8'h00;
      mask_end  <= 1'b1;
      fill_done <= 1'b0;
      armed_o   <= 1'b0;
      evt_end_o <= 1'b0;
    end else begin
      if (wr_valid_i && wr_addr_i == ADDR_CTRL) begin
        enable_o <= wr_data_i[CTRL_EN];
        access_o <= wr_data_i[CTRL_ACCESS];
      end
      if (wr_valid_i && wr_addr_i == ADDR_STAT) status_o <= wr_data_i[7:0];
      if (wr_valid_i && wr_addr_i == ADDR_MASK) mask_end <= wr_data_i[EVT_END];

      if (end_evt_i || fifo_clr_o)             fill_done <= 1'b0;
      else if (cmd_wr && wr_data_i[CMD_FILLED]) fill_done <= 1'b1;

      if (end_evt_i || fifo_clr_o)                         armed_o <= 1'b0;
      else if (cmd_wr && wr_data_i[CMD_START] && fill_done) armed_o <= 1'b1;

      if (end_evt_i)                          evt_end_o <= 1'b1;
      else if (evt_wr && wr_data_i[EVT_END]) evt_end_o <= 1'b0;
    end
  end

  assign irq_o = evt_end_o & ~mask_end;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_CTRL:  rd_data_o = {30'b0, access_o, enable_o};
      ADDR_STAT:  rd_data_o = {24'b0, status_o};
      ADDR_EVT:   rd_data_o = {31'b0, evt_end_o};
      ADDR_MASK:  rd_data_o = {31'b0, mask_end};
      ADDR_LEVEL: rd_data_o = REG_DW'(level_i);
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_tx_shifter.sv
`timescale 1ns/1ps
module spi_tx_shifter #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             armed_i,
  input  logic             fifo_clr_i,
  input  logic             cs_level_i,
  input  logic             cs_rise_i,
  input  logic             cs_fall_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  input  logic [7:0]       status_i,
  input  logic [PTR_W:0]   level_i,
  input  logic [7:0]       fifo_byte_i,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic             miso_o
);
  logic [7:0]     shreg;
  logic [3:0]     bitcnt;
  logic [PTR_W:0] rd_ptr;
  logic           use_fifo, load;
  logic [7:0]     next_byte;

  assign use_fifo  = armed_i && (rd_ptr < level_i);
  assign next_byte = use_fifo ? fifo_byte_i : status_i;
  assign load      = enable_i && (cs_fall_i ||
                     (!cs_level_i && sclk_fall_i && bitcnt == 4'd8));
  assign rd_idx_o  = rd_ptr[PTR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= 8'h00;
      bitcnt <= 4'd0;
      rd_ptr <= '0;
    end else if (cs_rise_i || fifo_clr_i) begin
      bitcnt <= 4'd0;
      rd_ptr <= '0;
    end else if (load) begin
      shreg  <= next_byte;
      bitcnt <= 4'd0;
      if (use_fifo) rd_ptr <= rd_ptr + 1'b1;
    end else if (enable_i && !cs_level_i) begin
      if (sclk_rise_i) bitcnt <= bitcnt + 1'b1;
      if (sclk_fall_i) shreg  <= {shreg[6:0], 1'b0};
    end
  end

  assign miso_o = enable_i & ~cs_level_i & shreg[7];
endmodule

// File: rtl/spi_tx_target.sv
`timescale 1ns/1ps
module spi_tx_target
  import spi_tx_pkg::*;
#(
  parameter int FIFO_BYTES  = 256,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_n_i,
  output logic              spi_miso_o,
  input  logic              reg_wr_valid_i,
  output logic              reg_wr_ready_o,
  input  logic [REG_AW-1:0] reg_wr_addr_i,
  input  logic [REG_DW-1:0] reg_wr_data_i,
  input  logic [REG_AW-1:0] reg_rd_addr_i,
  output logic [REG_DW-1:0] reg_rd_data_o,
  output logic              irq_o
);
  localparam int PTR_W = $clog2(FIFO_BYTES);
  localparam int LVL_W = PTR_W + 1;

  logic sclk_lvl, sclk_rise, sclk_fall;
  logic cs_lvl, cs_rise, cs_fall;
  logic ctl_enable, ctl_access, fifo_clr, fifo_push, tx_armed, evt_end, fifo_full;
  logic [7:0]       status_byte, fifo_byte;
  logic [LVL_W-1:0] fifo_level;
  logic [PTR_W-1:0] rd_idx;
  logic             end_evt;

  assign reg_wr_ready_o = 1'b1;
  assign end_evt        = cs_rise & ctl_enable;

  spi_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(spi_sclk_i),
    .level_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall));

  spi_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(spi_cs_n_i),
    .level_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall));

  spi_tx_regs #(.LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_valid_i(reg_wr_valid_i), .wr_addr_i(reg_wr_addr_i), .wr_data_i(reg_wr_data_i),
    .rd_addr_i(reg_rd_addr_i), .rd_data_o(reg_rd_data_o),
    .end_evt_i(end_evt), .level_i(fifo_level),
    .enable_o(ctl_enable), .access_o(ctl_access), .status_o(status_byte),
    .fifo_clr_o(fifo_clr), .push_o(fifo_push), .armed_o(tx_armed),
    .evt_end_o(evt_end), .irq_o(irq_o));

  spi_tx_fifo #(.WORD_W(WORD_W), .FIFO_BYTES(FIFO_BYTES)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr_i(fifo_clr), .push_i(fifo_push),
    .push_data_i(reg_wr_data_i[WORD_W-1:0]), .rd_idx_i(rd_idx),
    .level_o(fifo_level), .full_o(fifo_full), .rd_byte_o(fifo_byte));

  spi_tx_shifter #(.PTR_W(PTR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .enable_i(ctl_enable), .armed_i(tx_armed),
    .fifo_clr_i(fifo_clr), .cs_level_i(cs_lvl), .cs_rise_i(cs_rise),
    .cs_fall_i(cs_fall), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .status_i(status_byte), .level_i(fifo_level), .fifo_byte_i(fifo_byte),
    .rd_idx_o(rd_idx), .miso_o(spi_miso_o));
endmodule

// File: rtl/spi_tx_target_chk.sv
`timescale 1ns/1ps
module spi_tx_target_chk
  import spi_tx_pkg::*;
#(
  parameter int LVL_W      = 9,
  parameter int FIFO_BYTES = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              miso,
  input logic              cs_rise,
  input logic              evt_end,
  input logic              armed,
  input logic [LVL_W-1:0]  level,
  input logic              wr_fire,
  input logic [REG_AW-1:0] wr_addr,
  input logic [REG_DW-1:0] wr_data
);
  // R2
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !miso);

  // R8
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && enable) |=> evt_end);

  // R8
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && enable) |=> !armed);

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(FIFO_BYTES));

  // R10
  w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_end) |-> $past(wr_fire && wr_addr == ADDR_EVT && wr_data[EVT_END]));
endmodule

bind spi_tx_target spi_tx_target_chk #(.LVL_W(LVL_W), .FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(ctl_enable), .miso(spi_miso_o),
  .cs_rise(cs_rise), .evt_end(evt_end), .armed(tx_armed), .level(fifo_level),
  .wr_fire(reg_wr_valid_i), .wr_addr(reg_wr_addr_i), .wr_data(reg_wr_data_i));

// File: tb/spi_tx_target_test.sv
`timescale 1ns/1ps
module spi_tx_target_test;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, miso;
  logic wv = 0, wr_ready, irq;
  logic [3:0] wa = 0, ra = 0;
  logic [31:0] wd = 0, rd;

  int checks = 0, errors = 0;
  bit idle_chk = 0;

  // behavioural reference state
  int m_q[$];
  bit m_en = 0, m_acc = 0, m_fill = 0, m_armed = 0, m_evt = 0, m_mask = 1;
  int m_status = 0;

  always #10 clk = ~clk;

  spi_tx_target uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_cs_n_i(cs_n),
    .spi_miso_o(miso), .reg_wr_valid_i(wv), .reg_wr_ready_o(wr_ready),
    .reg_wr_addr_i(wa), .reg_wr_data_i(wd), .reg_rd_addr_i(ra),
    .reg_rd_data_o(rd), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2: MISO low whenever chip select idles, compared on every clock
  always @(negedge clk) if (idle_chk) chk(miso == 1'b0, "R2 idle miso", miso, 0);

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wv = 1; wa = a; wd = d;
    @(posedge clk);
    @(negedge clk); wv = 0;
    case (a)
      4'h0: begin m_en = d[0]; m_acc = d[1]; end
      4'h1: m_status = d[7:0];
      4'h2: begin
        if (d[0] || d[1]) begin m_q.delete(); m_fill = 0; m_armed = 0; end
        else begin
          if (d[3] && m_fill) m_armed = 1;
          if (d[2]) m_fill = 1;
        end
      end
      4'h3: if (m_acc && m_q.size() < 256)
              for (int k = 0; k < 4; k++) m_q.push_back((d >> (8*k)) & 8'hFF);
      4'h4: if (d[0]) m_evt = 0;
      4'h5: m_mask = d[0];
      default: ;
    endcase
  endtask

  task automatic rdreg(input logic [3:0] a, output int v);
    @(negedge clk); ra = a; #2; v = rd;
  endtask

  task automatic check_regs(input string req);
    int v;
    rdreg(4'h4, v); chk(v == int'(m_evt), req, v, m_evt);
    rdreg(4'h6, v); chk(v == m_q.size(), req, v, m_q.size());
    chk(irq == (m_evt & ~m_mask), "R9 irq", irq, m_evt & ~m_mask);
  endtask

  // one transaction of n bytes; byte-level expectations from the model
  task automatic xfer(input int n, input string req, input bit timed_release = 0);
    int ptr = 0;
    int exp;
    idle_chk = 0;
    cs_n = 0;
    repeat (6) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      if (!m_en) exp = 0;
      else if (m_armed && ptr < m_q.size()) begin exp = m_q[ptr]; ptr++; end
      else exp = m_status;
      for (int i = 7; i >= 0; i--) begin
        repeat (4) @(negedge clk);
        chk(miso == exp[i], req, miso, exp[i]);
        sclk = 1;
        repeat (4) @(negedge clk);
        sclk = 0;
      end
    end
    repeat (4) @(negedge clk);
    cs_n = 1;
    if (timed_release) begin
      // R10: clearing write lands on the edge where the release sets the flag
      @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
      wv = 1; wa = 4'h4; wd = 32'h1;
      @(posedge clk); @(negedge clk); wv = 0;
    end
    if (m_en) begin m_evt = 1; m_armed = 0; m_fill = 0; end
    repeat (6) @(negedge clk);
    idle_chk = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    idle_chk = 1;
    // R1 reset state
    rdreg(4'h0, v); chk(v == 0, "R1 ctrl", v, 0);
    rdreg(4'h1, v); chk(v == 0, "R1 status", v, 0);
    rdreg(4'h5, v); chk(v == 1, "R1 mask", v, 1);
    check_regs("R1 flags/level");
    chk(miso == 0, "R1 miso", miso, 0);

    // R2 disabled: low MISO, no flag
    wr(4'h1, 32'hFF);
    xfer(2, "R2 disabled");
    check_regs("R2 no flag");

    // R3 status byte, MSB first; R8 flag; R9 masked irq
    wr(4'h0, 32'h1);
    wr(4'h1, 32'hA5);
    xfer(3, "R3 status A5");
    check_regs("R8 flag set");
    wr(4'h5, 32'h0);
    check_regs("R9 unmasked");
    wr(4'h4, 32'hFF);
    check_regs("R10 w1c");
    wr(4'h1, 32'h3C);
    xfer(2, "R3 new status");

    // R4 no push without access bit
    wr(4'h3, 32'h12345678);
    check_regs("R4 gated");
    wr(4'h0, 32'h3);
    wr(4'h3, 32'h44332211);
    wr(4'h3, 32'h88776655);
    check_regs("R4 level 8");
    xfer(2, "R6 not armed");
    // R6 start without fill-done does not arm
    wr(4'h2, 32'h8);
    xfer(2, "R6 start alone");
    // R6/R7 armed stream, LSB of each word first, then status
    wr(4'h2, 32'h4);
    wr(4'h2, 32'h8);
    xfer(10, "R6 R7 stream");
    check_regs("R8 data kept");
    // R8 disarmed after release
    xfer(2, "R8 disarmed");

    // R5 reset empties store and disarms
    wr(4'h2, 32'h4);
    wr(4'h2, 32'h8);
    wr(4'h2, 32'h1);
    check_regs("R5 empty");
    wr(4'h2, 32'h4);
    wr(4'h2, 32'h8);
    xfer(2, "R5 empty stream");
    wr(4'h3, 32'hCAFEF00D);
    wr(4'h2, 32'h2);
    check_regs("R5 count reset");

    // R4 full store, overflow dropped; R7 status after 256 bytes
    for (int k = 0; k < 64; k++)
      wr(4'h3, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    wr(4'h3, 32'hDEADBEEF);
    check_regs("R4 full 256");
    wr(4'h1, 32'h5A);
    wr(4'h2, 32'h4);
    wr(4'h2, 32'h8);
    xfer(258, "R6 R7 full stream");

    // R10 set and clear in the same cycle: set wins
    wr(4'h4, 32'h1);
    xfer(1, "R3 pre", 1'b1);
    check_regs("R10 set wins");
    wr(4'h4, 32'h1);
    check_regs("R10 clear");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule